// File: doc/BRIEF.md
# Shared-Bus Master Access Bridge

This block sits between a processor and a multi-master system bus that it shares with other masters. A processor request names a space (memory or I/O), a direction, a starting address, a byte count from 1 to `NB` and, for writes, the data. The bridge adds a programmable offset to the address. It then asks for the bus and waits for the grant. It carries the request out as a series of 8-bit or 16-bit bus cycles. Each cycle keeps its command strobe asserted until the addressed slave acknowledges.

When a request needs more than one bus cycle, the bridge holds a lock output so that it keeps ownership between those cycles. After the last acknowledge it drops the bus request and gives the processor a one-cycle completion pulse, together with the assembled read data. I/O accesses are formed in exactly the same way as memory accesses, but use the I/O command strobes. No access ever bypasses the bus. A synchronous initialization input abandons any request in progress.

Top module: `sysbus_master_bridge`

## Requirements
- R1: The bus address of every cycle is the processor address plus the offset register, modulo 2^AW, advanced by the bytes already moved. The offset register loads from `ofs_wdata_i` one cycle after `ofs_we_i`, and resets to zero.
- R2: A request with `req_i` high and a non-zero `req_len_i`, taken while idle, raises `breq_o` on the next cycle. No command strobe is asserted until `bgnt_i` has been sampled high.
- R3: Once asserted, a command strobe and its address stay unchanged for as long as `xack_i` is low, with no time limit. With an acknowledge delay of D cycles, the strobe is high for exactly D+1 cycles.
- R4: A cycle is 16 bits wide (`bw16_o`=1) when at least two bytes remain and the bus address is even; otherwise it is 8 bits wide. The byte at the lower address travels on data bits 7:0 and the next byte on bits 15:8. On `rdata_o` and `req_wdata_i`, byte k (bits 8k+7:8k) belongs to address+k.
- R5: A request that needs more than one cycle keeps `breq_o` high and `lock_o` high from its first strobe to its last. The strobes drop for exactly one cycle between the bus cycles. A single-cycle request never raises `lock_o`.
- R6: `breq_o` falls on the cycle after the last acknowledge, and is low while `done_o` is high.
- R7: `done_o` is high for exactly one cycle, the cycle after the last acknowledge. On that cycle `rdata_o` holds the bytes read, and bytes beyond the count are zero.
- R8: Memory requests use only `mrd_o`/`mwr_o`. I/O requests use only `iord_o`/`iowr_o` and are addressed through the same offset path. At most one strobe is high at a time.
- R9: With `init_i` high at a clock edge, the next cycle has `breq_o`, `lock_o` and every strobe low. The aborted request never raises `done_o`, and the bridge accepts a new request afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| init_i | input | 1 | Synchronous system initialization, aborts any request |
| ofs_we_i | input | 1 | Offset register write enable |
| ofs_wdata_i | input | AW | Offset register write value |
| req_i | input | 1 | Processor request strobe, sampled while idle |
| req_io_i | input | 1 | 1 = I/O space, 0 = memory space |
| req_wr_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | AW | Processor start address |
| req_len_i | input | CW | Byte count, 1 to NB |
| req_wdata_i | input | 8*NB | Write bytes, byte k for address+k |
| done_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | 8*NB | Assembled read bytes |
| breq_o | output | 1 | Bus request |
| bgnt_i | input | 1 | Bus grant |
| lock_o | output | 1 | Bus lock across a multi-cycle request |
| baddr_o | output | AW | Bus address |
| bw16_o | output | 1 | Current cycle is 16 bits wide |
| bdata_o | output | 16 | Bus write data |
| bdata_oe_o | output | 1 | Bus write data valid |
| bdata_i | input | 16 | Bus read data |
| mrd_o | output | 1 | Memory read command |
| mwr_o | output | 1 | Memory write command |
| iord_o | output | 1 | I/O read command |
| iowr_o | output | 1 | I/O write command |
| xack_i | input | 1 | Transfer acknowledge from slave |

## Verification
The bench counts cycles at falling edges. A request taken at one rising edge shows `breq_o` after that edge and a strobe one edge after the grant is sampled. `done_o` must appear exactly one counted cycle after the cycle in which the acknowledge was driven, so the bench records both cycle numbers and checks that they differ by one. It also checks that `breq_o` is already low at that sample. For a slave delay of D, the strobe must be seen on D+1 consecutive falling edges. After an initialization pulse, the outputs are sampled at the first falling edge past the next rising edge.

// File: rtl/sb_pkg.sv
package sb_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ARB  = 2'd1,
    ST_CMD  = 2'd2,
    ST_GAP  = 2'd3
  } sb_state_e;
endpackage

// File: rtl/sb_offset_reg.sv
module sb_offset_reg #(
  parameter int AW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] wdata_i,
  output logic [AW-1:0] ofs_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   ofs_o <= '0;
    else if (we_i) ofs_o <= wdata_i;
  end

  assert_ofs_load_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> ofs_o == $past(wdata_i));
endmodule

// File: rtl/sb_chunk_plan.sv
module sb_chunk_plan #(
  parameter int CW = 3
) (
  input  logic          addr_lsb_i,
  input  logic [CW-1:0] rem_i,
  output logic          wide_o,
  output logic [CW-1:0] step_o
);
  always_comb begin
    wide_o = (rem_i >= CW'(2)) && !addr_lsb_i;
    step_o = wide_o ? CW'(2) : CW'(1);
  end
endmodule

// File: rtl/sb_byte_lanes.sv
module sb_byte_lanes #(
  parameter int NB = 4,
  parameter int IW = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            clr_i,
  input  logic            ack_i,
  input  logic            wide_i,
  input  logic [IW-1:0]   idx_i,
  input  logic [8*NB-1:0] wdata_i,
  input  logic [15:0]     bdata_i,
  output logic [15:0]     bdata_o,
  output logic [8*NB-1:0] rdata_o
);
  logic [7:0] wb [NB];
  logic [IW:0] idx_x, nxt_x;
  logic [7:0] lo_b, hi_b;

  assign idx_x = {1'b0, idx_i};
  assign nxt_x = idx_x + 1'b1;

  for (genvar k = 0; k < NB; k++) begin : g_byte
    localparam logic [IW:0] KK = k;
    assign wb[k] = wdata_i[8*k +: 8];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                        rdata_o[8*k +: 8] <= '0;
      else if (clr_i)                     rdata_o[8*k +: 8] <= '0;
      else if (ack_i && idx_x == KK)      rdata_o[8*k +: 8] <= bdata_i[7:0];
      else if (ack_i && wide_i && nxt_x == KK) rdata_o[8*k +: 8] <= bdata_i[15:8];
    end
  end

  always_comb begin
    lo_b = wb[idx_i];
    hi_b = (nxt_x < NB) ? wb[nxt_x[IW-1:0]] : 8'h00;
    bdata_o = wide_i ? {hi_b, lo_b} : {8'h00, lo_b};
  end
endmodule

// File: rtl/sysbus_master_bridge.sv
module sysbus_master_bridge
  import sb_pkg::*;
#(
  parameter int AW = 16,
  parameter int NB = 4,
  localparam int CW = $clog2(NB + 1),
  localparam int IW = (NB > 1) ? $clog2(NB) : 1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            init_i,
  input  logic            ofs_we_i,
  input  logic [AW-1:0]   ofs_wdata_i,
  input  logic            req_i,
  input  logic            req_io_i,
  input  logic            req_wr_i,
  input  logic [AW-1:0]   req_addr_i,
  input  logic [CW-1:0]   req_len_i,
  input  logic [8*NB-1:0] req_wdata_i,
  output logic            done_o,
  output logic [8*NB-1:0] rdata_o,
  output logic            breq_o,
  input  logic            bgnt_i,
  output logic            lock_o,
  output logic [AW-1:0]   baddr_o,
  output logic            bw16_o,
  output logic [15:0]     bdata_o,
  output logic            bdata_oe_o,
  input  logic [15:0]     bdata_i,
  output logic            mrd_o,
  output logic            mwr_o,
  output logic            iord_o,
  output logic            iowr_o,
  input  logic            xack_i
);
  sb_state_e       st_q;
  logic [AW-1:0]   addr_q, ofs;
  logic [CW-1:0]   rem_q, step;
  logic [IW-1:0]   idx_q;
  logic            io_q, wr_q, multi_q, done_q, wide, cmd, take;
  logic [8*NB-1:0] wdata_q;

  sb_offset_reg #(.AW(AW)) u_ofs (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(ofs_we_i),
    .wdata_i(ofs_wdata_i), .ofs_o(ofs)
  );

  sb_chunk_plan #(.CW(CW)) u_plan (
    .addr_lsb_i(addr_q[0]), .rem_i(rem_q), .wide_o(wide), .step_o(step)
  );

  assign take = (st_q == ST_IDLE) && req_i && (req_len_i != '0) && !init_i;
  assign cmd  = (st_q == ST_CMD);

  sb_byte_lanes #(.NB(NB), .IW(IW)) u_lanes (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(take),
    .ack_i(cmd && xack_i && !wr_q && !init_i), .wide_i(wide),
    .idx_i(idx_q), .wdata_i(wdata_q), .bdata_i(bdata_i),
    .bdata_o(bdata_o), .rdata_o(rdata_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= ST_IDLE; addr_q <= '0; rem_q <= '0; idx_q <= '0;
      io_q <= 1'b0; wr_q <= 1'b0; multi_q <= 1'b0; done_q <= 1'b0;
      wdata_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (init_i) begin
        st_q    <= ST_IDLE;
        multi_q <= 1'b0;
      end else begin
        case (st_q)
          ST_IDLE: if (take) begin
            st_q    <= ST_ARB;
            addr_q  <= req_addr_i + ofs;
            rem_q   <= req_len_i;
            idx_q   <= '0;
            io_q    <= req_io_i;
            wr_q    <= req_wr_i;
            wdata_q <= req_wdata_i;
          end
          ST_ARB: if (bgnt_i) begin
            st_q    <= ST_CMD;
            multi_q <= rem_q > step;
          end
          ST_CMD: if (xack_i) begin
            addr_q <= addr_q + AW'(step);
            rem_q  <= rem_q - step;
            idx_q  <= idx_q + IW'(step);
            if (rem_q == step) begin
              st_q    <= ST_IDLE;
              multi_q <= 1'b0;
              done_q  <= 1'b1;
            end else begin
              st_q <= ST_GAP;
            end
          end
          ST_GAP:  st_q <= ST_CMD;
          default: st_q <= ST_IDLE;
        endcase
      end
    end
  end

  assign done_o     = done_q;
  assign breq_o     = (st_q != ST_IDLE);
  assign lock_o     = multi_q && (cmd || st_q == ST_GAP);
  assign baddr_o    = addr_q;
  assign bw16_o     = cmd && wide;
  assign bdata_oe_o = cmd && wr_q;
  assign mrd_o      = cmd && !io_q && !wr_q;
  assign mwr_o      = cmd && !io_q &&  wr_q;
  assign iord_o     = cmd &&  io_q && !wr_q;
  assign iowr_o     = cmd &&  io_q &&  wr_q;

  logic any_stb;
  assign any_stb = mrd_o | mwr_o | iord_o | iowr_o;

  assert_one_strobe_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({mrd_o, mwr_o, iord_o, iowr_o}));
  assert_wait_grant_R2: assert property (@(posedge clk_i) disable iff (!rst_ni || init_i)
    (st_q == ST_ARB && !bgnt_i) |=> !any_stb);
  assert_hold_cmd_R3: assert property (@(posedge clk_i) disable iff (!rst_ni || init_i)
    (any_stb && !xack_i) |=> any_stb && $stable(baddr_o) && $stable({mrd_o, mwr_o, iord_o, iowr_o}));
  assert_wide_even_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bw16_o |-> !baddr_o[0]);
  assert_lock_owned_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_o |-> breq_o);
  assert_release_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !breq_o);
  assert_done_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  assert_init_abort_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_i |=> !breq_o && !lock_o && !any_stb && !done_o);
endmodule

// File: tb/sysbus_master_bridge_test.sv
module sysbus_master_bridge_test;
  localparam int AW = 16;
  localparam int NB = 4;
  localparam int CW = $clog2(NB + 1);

  logic clk = 1'b0, rst_ni = 1'b0, init_i = 1'b0;
  logic ofs_we_i = 1'b0;
  logic [AW-1:0] ofs_wdata_i = '0;
  logic req_i = 1'b0, req_io_i = 1'b0, req_wr_i = 1'b0;
  logic [AW-1:0] req_addr_i = '0;
  logic [CW-1:0] req_len_i = '0;
  logic [8*NB-1:0] req_wdata_i = '0;
  logic done_o, breq_o, lock_o, bw16_o, bdata_oe_o;
  logic mrd_o, mwr_o, iord_o, iowr_o;
  logic [8*NB-1:0] rdata_o;
  logic [AW-1:0] baddr_o;
  logic [15:0] bdata_o;
  logic [15:0] bdata_i = '0;
  logic bgnt_i = 1'b0, xack_i = 1'b0;

  always #4 clk = ~clk;

  sysbus_master_bridge #(.AW(AW), .NB(NB)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .init_i(init_i),
    .ofs_we_i(ofs_we_i), .ofs_wdata_i(ofs_wdata_i),
    .req_i(req_i), .req_io_i(req_io_i), .req_wr_i(req_wr_i),
    .req_addr_i(req_addr_i), .req_len_i(req_len_i), .req_wdata_i(req_wdata_i),
    .done_o(done_o), .rdata_o(rdata_o), .breq_o(breq_o), .bgnt_i(bgnt_i),
    .lock_o(lock_o), .baddr_o(baddr_o), .bw16_o(bw16_o), .bdata_o(bdata_o),
    .bdata_oe_o(bdata_oe_o), .bdata_i(bdata_i), .mrd_o(mrd_o), .mwr_o(mwr_o),
    .iord_o(iord_o), .iowr_o(iowr_o), .xack_i(xack_i)
  );

  int n_chk = 0, n_bad = 0;
  logic [7:0] mem [256];
  int gnt_delay = 0, ack_delay = 0, gcnt = 0, acnt = 0;
  int cyc = 0, n_xfer, n_wide, n_rise, n_stb, nogrant, memseen, ioseen;
  int breq_fall, done_cnt, done_cyc, ack_cyc;
  logic lock_seen, breq_at_done, prev_stb = 1'b0, prev_breq = 1'b0, stb;
  logic [AW-1:0] first_addr, second_addr;
  logic [8*NB-1:0] rdata_cap;
  logic [7:0] a;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clr_stats();
    n_xfer = 0; n_wide = 0; n_rise = 0; n_stb = 0; nogrant = 0; memseen = 0;
    ioseen = 0; breq_fall = 0; done_cnt = 0; done_cyc = 0; ack_cyc = 0;
    lock_seen = 1'b0; breq_at_done = 1'b0; first_addr = '0; second_addr = '0;
    rdata_cap = '0;
  endtask

  task automatic step();
    @(posedge clk); #2;
  endtask

  // Monitor and bus slave, both at the falling edge
  always @(negedge clk) begin
    cyc = cyc + 1;
    stb = mrd_o | mwr_o | iord_o | iowr_o;
    if (stb && !prev_stb) n_rise++;
    if (stb) begin
      n_stb++;
      if (!bgnt_i) nogrant++;
      if (mrd_o || mwr_o) memseen++;
      if (iord_o || iowr_o) ioseen++;
      if (lock_o) lock_seen = 1'b1;
    end
    if (prev_breq && !breq_o) breq_fall++;
    if (done_o) begin
      done_cnt++; done_cyc = cyc; rdata_cap = rdata_o; breq_at_done = breq_o;
    end
    prev_stb = stb; prev_breq = breq_o;
    if (!rst_ni) begin
      bgnt_i = 1'b0; xack_i = 1'b0; gcnt = 0; acnt = 0;
    end else begin
      if (breq_o) begin
        if (gcnt >= gnt_delay) bgnt_i = 1'b1; else gcnt++;
      end else begin
        bgnt_i = 1'b0; gcnt = 0;
      end
      if (stb && !xack_i) begin
        if (acnt >= ack_delay) begin
          xack_i = 1'b1; acnt = 0; n_xfer++; ack_cyc = cyc;
          if (n_xfer == 1) first_addr = baddr_o;
          if (n_xfer == 2) second_addr = baddr_o;
          if (bw16_o) n_wide++;
          a = baddr_o[7:0];
          if (mwr_o || iowr_o) begin
            mem[a] = bdata_o[7:0];
            if (bw16_o) mem[a + 8'd1] = bdata_o[15:8];
          end else begin
            bdata_i = {mem[a + 8'd1], mem[a]};
          end
        end else acnt++;
      end else begin
        xack_i = 1'b0; acnt = 0;
      end
    end
  end

  task automatic set_ofs(input logic [AW-1:0] v);
    ofs_we_i = 1'b1; ofs_wdata_i = v; step(); ofs_we_i = 1'b0; step();
  endtask

  task automatic do_req(input logic io, input logic wr, input logic [AW-1:0] ad,
                        input int len, input logic [8*NB-1:0] wd);
    clr_stats();
    req_io_i = io; req_wr_i = wr; req_addr_i = ad; req_len_i = CW'(len);
    req_wdata_i = wd; req_i = 1'b1;
    step(); req_i = 1'b0;
    for (int i = 0; i < 3000; i++) begin
      if (done_cnt != 0) break;
      step();
    end
    repeat (3) step();
  endtask

  task automatic t_reset();
    check("R2 reset breq", breq_o, 0);
    check("R7 reset done", done_o, 0);
    check("R8 reset strobes", {mrd_o, mwr_o, iord_o, iowr_o, lock_o}, 0);
  endtask

  task automatic t_single_write();
    do_req(1'b0, 1'b1, 16'h0020, 1, 32'h0000_005A);
    check("R1 zero offset addr", first_addr, 16'h0020);
    check("R4 byte stored", mem[8'h20], 8'h5A);
    check("R4 narrow", n_wide, 0);
    check("R5 no lock single", lock_seen, 0);
    check("R6 breq low at done", breq_at_done, 0);
    check("R7 done one cycle after ack", done_cyc - ack_cyc, 1);
    check("R7 done width", done_cnt, 1);
  endtask

  task automatic t_offset();
    set_ofs(16'h0013);
    do_req(1'b0, 1'b1, 16'h0020, 1, 32'h0000_00C3);
    check("R1 offset addr", first_addr, 16'h0033);
    check("R1 offset data", mem[8'h33], 8'hC3);
    set_ofs(16'h0030);
    do_req(1'b0, 1'b1, 16'hFFE0, 1, 32'h0000_0077);
    check("R1 offset wrap", first_addr, 16'h0010);
    set_ofs(16'h0000);
  endtask

  task automatic t_word_write();
    do_req(1'b0, 1'b1, 16'h0050, 4, 32'hDDCC_BBAA);
    check("R4 two cycles", n_xfer, 2);
    check("R4 both wide", n_wide, 2);
    check("R1 second addr", second_addr, 16'h0052);
    check("R4 lanes", {mem[8'h53], mem[8'h52], mem[8'h51], mem[8'h50]}, 32'hDDCC_BBAA);
    check("R5 lock held", lock_seen, 1);
    check("R5 no mid release", breq_fall, 1);
    check("R5 strobe gap", n_rise, 2);
  endtask

  task automatic t_odd_read();
    mem[8'h41] = 8'h11; mem[8'h42] = 8'h22; mem[8'h43] = 8'h33; mem[8'h44] = 8'h44;
    do_req(1'b0, 1'b0, 16'h0041, 3, '0);
    check("R4 odd split count", n_xfer, 2);
    check("R4 odd split wide", n_wide, 1);
    check("R7 read data", rdata_cap, 32'h0033_2211);
    check("R8 mem read strobe", ioseen, 0);
    check("R7 read done timing", done_cyc - ack_cyc, 1);
    do_req(1'b0, 1'b0, 16'h0043, 2, '0);
    check("R4 two odd bytes narrow", {n_xfer[7:0], n_wide[7:0]}, 16'h0200);
    check("R7 two byte read", rdata_cap, 32'h0000_4433);
  endtask

  task automatic t_io();
    do_req(1'b1, 1'b1, 16'h0060, 2, 32'h0000_BEEF);
    check("R8 io strobe used", ioseen > 0, 1);
    check("R8 no mem strobe", memseen, 0);
    check("R8 io data", {mem[8'h61], mem[8'h60]}, 16'hBEEF);
    check("R8 io one cycle", n_xfer, 1);
  endtask

  task automatic t_slow_ack();
    ack_delay = 20;
    do_req(1'b0, 1'b0, 16'h0041, 1, '0);
    check("R3 strobe held", n_stb, 21);
    check("R3 completes", done_cnt, 1);
    ack_delay = 0;
  endtask

  task automatic t_grant_delay();
    gnt_delay = 6;
    do_req(1'b0, 1'b1, 16'h0070, 2, 32'h0000_0102);
    check("R2 no strobe before grant", nogrant, 0);
    check("R2 completes after grant", {mem[8'h71], mem[8'h70]}, 16'h0102);
    gnt_delay = 0;
  endtask

  task automatic t_init();
    ack_delay = 50;
    clr_stats();
    req_io_i = 1'b0; req_wr_i = 1'b0; req_addr_i = 16'h0041; req_len_i = CW'(4);
    req_i = 1'b1; step(); req_i = 1'b0;
    repeat (5) step();
    check("R5 lock during multi", lock_o, 1);
    init_i = 1'b1; step(); init_i = 1'b0;
    check("R9 abort outputs", {breq_o, lock_o, mrd_o, mwr_o, iord_o, iowr_o}, 0);
    repeat (60) step();
    check("R9 no done after abort", done_cnt, 0);
    ack_delay = 0;
    do_req(1'b0, 1'b0, 16'h0042, 2, '0);
    check("R9 usable after abort", rdata_cap, 32'h0000_3322);
  endtask

  initial begin
    clr_stats();
    repeat (3) @(posedge clk);
    #2;
    t_reset();
    rst_ni = 1'b1;
    step();
    t_reset();
    t_single_write();
    t_offset();
    t_word_write();
    t_odd_read();
    t_io();
    t_slow_ack();
    t_grant_delay();
    t_init();
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule